// File: doc/BRIEF.md
# Dual-Lane Interleaved Serializer

This block turns a 2N-bit parallel word into two serial streams. Bits with even indices travel on lane 0 and bits with odd indices on lane 1. Each lane is an N-to-1 shift serializer that sends one bit per fast-clock cycle, least significant position first. Lane 0 acts on the rising edge of the fast clock. Lane 1 acts on the falling edge, so its stream sits half a cycle ahead of lane 0. A downstream merger can therefore interleave the two lanes into a double-rate stream.

An internal modulo-N counter sets the frame. Its divided clock is exported so that upstream logic can present a new word once per frame. The word must stay stable from the start of the frame-start cycle until the rising edge that ends it. There is no valid/ready handshake, because the serializer takes exactly one word per frame and cannot exert back-pressure.

The reset input has two meanings, selected by the parameter `ASYNC_RST`:
- **`ASYNC_RST` = 1:** the input is an asynchronous active-high reset. A two-flop synchronizer turns it into a clean active-low reset.
- **`ASYNC_RST` = 0:** the input is already a synchronous active-low reset, and it drives the lanes directly.

Top module: `ilv_dual_serializer`

## Requirements
- R1: Input bit 2k is serialized on `dout[0]` and input bit 2k+1 on `dout[1]`, each in frame position k for k = 0..N-1.
- R2: Lane 1 loads and shifts on falling edges and lane 0 on rising edges. Within a frame, lane 1 presents position k half a cycle before lane 0 presents position k, so in the frame-start cycle `dout[0]` still shows the previous frame's last bit.
- R3: Each lane sends its N bits in position order 0 first, one bit per fast-clock cycle, with back-to-back frames and no gap.
- R4: `clk_div` is high during frame cycles 0..N/2-1 (integer division) and low for the rest of the frame. The frame-start cycle is cycle 0.
- R5: With `ASYNC_RST`=1, `rst_n_sync` goes low as soon as `rst_raw` goes high. After `rst_raw` is released, `rst_n_sync` rises at the second rising edge of `clk`.
- R6: While the internal reset is low, both outputs are 0 and the frame counter is held at frame cycle 0, so `clk_div` is 1.
- R7: With `ASYNC_RST`=0, `rst_n_sync` equals `rst_raw` (active low), which resets the lanes synchronously. The first fast-clock cycle after release is frame cycle 0.
- R8: A reset asserted in mid-stream aborts the frame. After release, serialization restarts at position 0 of the word present at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock; lane 0 uses rising edges, lane 1 falling edges |
| rst_raw | input | 1 | Async active-high reset (ASYNC_RST=1) or sync active-low reset (ASYNC_RST=0) |
| din | input | 2*N | Parallel word; even bits to lane 0, odd bits to lane 1 |
| dout | output | 2 | Serial outputs, index = lane |
| clk_div | output | 1 | Divided frame clock, high for the first half of each frame |
| rst_n_sync | output | 1 | Active-low reset applied to both lanes |

## Verification
The embedded assertions check the following on every cycle:
- The synchronizer holds its output low during reset and releases it only after its first stage has gone high.
- Each lane presents position 0 on the edge after a load.
- Load pulses never occur in adjacent cycles and always fall inside the high half of `clk_div`.
- Lane outputs are 0 after any reset edge.

The bench scenarios cover what the assertions cannot:
- The full even/odd mapping across several frame patterns.
- The half-cycle offset between the lanes.
- The exact release latency of the reset.
- Restart from position 0 after a mid-stream reset.
- Direct-reset behaviour of the synchronous variant.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // number of frame cycles during which the divided clock is high
  function automatic int high_cycles(input int n);
    return n / 2;
  endfunction
endpackage

// File: rtl/ser_rst_ctl.sv
module ser_rst_ctl #(
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_raw,
  output logic rst_n_o
);
  generate
    if (ASYNC_RST) begin : g_sync
      logic stage1, stage2;
      always_ff @(posedge clk or posedge rst_raw) begin
        if (rst_raw) begin
          stage1 <= 1'b0;
          stage2 <= 1'b0;
        end else begin
          stage1 <= 1'b1;
          stage2 <= stage1;
        end
      end
      assign rst_n_o = stage2;

      // R5: output stays low whenever the raw reset is seen active
      p_hold_low_r5: assert property (@(posedge clk) rst_raw |-> !rst_n_o)
        else $error("reset output high during raw reset");
      // R5: release only after the first stage is already high
      p_two_stage_r5: assert property (@(posedge clk) disable iff (rst_raw)
        $rose(rst_n_o) |-> $past(stage1))
        else $error("reset released without first stage");
    end else begin : g_direct
      assign rst_n_o = rst_raw;
    end
  endgenerate
endmodule

// File: rtl/ser_frame_ctr.sv
module ser_frame_ctr #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic load,
  output logic clk_div
);
  import ser_pkg::*;
  localparam int CW   = (N > 1) ? $clog2(N) : 1;
  localparam int HALF = high_cycles(N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt <= '0;
    else if (cnt == CW'(N - 1))    cnt <= '0;
    else                           cnt <= cnt + 1'b1;
  end

  assign load    = (cnt == '0);
  assign clk_div = (int'(cnt) < HALF);

  // R4: the load cycle lies inside the high half of the divided clock
  p_load_in_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> clk_div)
    else $error("load outside high phase");
  // R3: frames are N cycles long, so loads are never adjacent
  p_load_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load)
    else $error("back-to-back load");
endmodule

// File: rtl/ser_lane.sv
module ser_lane #(
  parameter int N       = 4,
  parameter bit FALLING = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] par,
  output logic         dout
);
  logic [N-1:0] sh;

  generate
    if (FALLING) begin : g_neg
      always_ff @(negedge clk) begin
        if (!rst_n) begin
          sh   <= '0;
          dout <= 1'b0;
        end else if (load) begin
          sh   <= par >> 1;
          dout <= par[0];
        end else begin
          sh   <= sh >> 1;
          dout <= sh[0];
        end
      end
      // R6: output cleared after a reset edge
      p_rst_zero_r6: assert property (@(negedge clk) !rst_n |=> !dout)
        else $error("lane output not cleared");
      // R3: position 0 appears right after a load
      p_first_bit_r3: assert property (@(negedge clk) disable iff (!rst_n)
        load |=> dout == $past(par[0]))
        else $error("lane did not start at position 0");
    end else begin : g_pos
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh   <= '0;
          dout <= 1'b0;
        end else if (load) begin
          sh   <= par >> 1;
          dout <= par[0];
        end else begin
          sh   <= sh >> 1;
          dout <= sh[0];
        end
      end
      // R6: output cleared after a reset edge
      p_rst_zero_r6: assert property (@(posedge clk) !rst_n |=> !dout)
        else $error("lane output not cleared");
      // R3: position 0 appears right after a load
      p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(par[0]))
        else $error("lane did not start at position 0");
    end
  endgenerate
endmodule

// File: rtl/ilv_dual_serializer.sv
module ilv_dual_serializer #(
  parameter int N         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic           clk,
  input  logic           rst_raw,
  input  logic [2*N-1:0] din,
  output logic [1:0]     dout,
  output logic           clk_div,
  output logic           rst_n_sync
);
  logic         load;
  logic [N-1:0] even_bits, odd_bits;

  // R1: interleaved split of the parallel word
  for (genvar k = 0; k < N; k++) begin : g_split
    assign even_bits[k] = din[2*k];
    assign odd_bits[k]  = din[2*k+1];
  end

  ser_rst_ctl #(.ASYNC_RST(ASYNC_RST)) u_rst (
    .clk(clk), .rst_raw(rst_raw), .rst_n_o(rst_n_sync)
  );

  ser_frame_ctr #(.N(N)) u_ctr (
    .clk(clk), .rst_n(rst_n_sync), .load(load), .clk_div(clk_div)
  );

  ser_lane #(.N(N), .FALLING(1'b0)) u_lane0 (
    .clk(clk), .rst_n(rst_n_sync), .load(load), .par(even_bits), .dout(dout[0])
  );

  ser_lane #(.N(N), .FALLING(1'b1)) u_lane1 (
    .clk(clk), .rst_n(rst_n_sync), .load(load), .par(odd_bits), .dout(dout[1])
  );
endmodule

// File: tb/ilv_dual_serializer_tb.sv
module ilv_dual_serializer_tb;
  localparam int N = 4;
  localparam int W = 2 * N;
  localparam int FRAMES = 6;
  localparam int HALF = N / 2;

  logic clk = 1'b0;
  logic rst_raw, rst_raw_s;
  logic [W-1:0] din;
  logic [1:0] dout, dout_s;
  logic clk_div, clk_div_s, rst_n_sync, rst_n_sync_s;

  int n_checks = 0, n_fail = 0;
  bit q0[$];
  bit q1[$];

  always #4 clk = ~clk;

  ilv_dual_serializer #(.N(N), .ASYNC_RST(1'b1)) u_dut (
    .clk(clk), .rst_raw(rst_raw), .din(din), .dout(dout),
    .clk_div(clk_div), .rst_n_sync(rst_n_sync)
  );

  ilv_dual_serializer #(.N(N), .ASYNC_RST(1'b0)) u_dut_s (
    .clk(clk), .rst_raw(rst_raw_s), .din(din), .dout(dout_s),
    .clk_div(clk_div_s), .rst_n_sync(rst_n_sync_s)
  );

  function automatic logic [W-1:0] word_of(input int f);
    if (f == 1) return '1;
    if (f == 2) return '0;
    return W'(8'hA5 ^ (f * 8'h37));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_word(input logic [W-1:0] w);
    for (int k = 0; k < N; k++) begin
      q0.push_back(w[2*k]);
      q1.push_back(w[2*k+1]);
    end
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_raw = 1'b1;
    rst_raw_s = 1'b0;
    din = word_of(0);
    repeat (3) @(posedge clk);
    #6;
    chk(dout == 2'b00, "R6 reset outputs", dout, 0);
    chk(clk_div == 1'b1, "R6 clk_div in reset", clk_div, 1);
    chk(rst_n_sync == 1'b0, "R5 reset low", rst_n_sync, 0);
    @(posedge clk); #1 rst_raw = 1'b0;
    push_word(word_of(0));
    @(posedge clk); #6;
    chk(rst_n_sync == 1'b0, "R5 still low after one edge", rst_n_sync, 0);
    fork
      begin : driver
        @(posedge clk);
        for (int f = 0; f < FRAMES; f++) begin
          @(posedge clk); #1;
          din = word_of(f + 1);
          push_word(word_of(f + 1));
          repeat (N - 1) @(posedge clk);
        end
      end
      begin : monitor
        @(posedge clk);
        for (int i = 0; i < FRAMES * N; i++) begin
          #6;
          if (i == 0) chk(rst_n_sync == 1'b1, "R5 released after two edges", rst_n_sync, 1);
          chk(clk_div == ((i % N) < HALF), "R4 divided clock", clk_div, int'((i % N) < HALF));
          begin
            bit e1;
            e1 = q1.pop_front();
            chk(dout[1] == e1, "R1 R3 lane1 odd bit", dout[1], e1);
          end
          if (i == 0) begin
            chk(dout[0] == 1'b0, "R2 lane0 lags half cycle", dout[0], 0);
          end else begin
            bit e0;
            e0 = q0.pop_front();
            chk(dout[0] == e0, "R1 R2 R3 lane0 even bit", dout[0], e0);
          end
          @(posedge clk);
        end
      end
    join

    // R8: mid-stream reset
    @(posedge clk); @(negedge clk); #1 rst_raw = 1'b1;
    #1;
    chk(rst_n_sync == 1'b0, "R5 immediate assert", rst_n_sync, 0);
    @(posedge clk); #6;
    chk(dout == 2'b00, "R8 outputs cleared", dout, 0);
    chk(clk_div == 1'b1, "R8 frame counter reset", clk_div, 1);
    @(posedge clk); #1 rst_raw = 1'b0;
    @(posedge clk);
    @(posedge clk); #6;
    chk(dout[1] == din[1], "R8 restart lane1 position 0", dout[1], din[1]);
    @(posedge clk); #6;
    chk(dout[0] == din[0], "R8 restart lane0 position 0", dout[0], din[0]);

    // R7: synchronous-reset variant
    chk(dout_s == 2'b00, "R7 sync variant held in reset", dout_s, 0);
    chk(rst_n_sync_s == 1'b0, "R7 reset passthrough low", rst_n_sync_s, 0);
    @(posedge clk); #1 rst_raw_s = 1'b1;
    #1;
    chk(rst_n_sync_s == 1'b1, "R7 reset passthrough high", rst_n_sync_s, 1);
    #4;
    chk(dout_s[1] == din[1], "R7 lane1 first bit", dout_s[1], din[1]);
    @(posedge clk); #6;
    chk(dout_s[0] == din[0], "R7 lane0 first bit", dout_s[0], din[0]);
    chk(clk_div_s == 1'b1, "R7 R4 frame cycle 1 high", clk_div_s, 1);
    chk(dout_s[1] == din[3], "R7 R3 lane1 second bit", dout_s[1], din[3]);
    finish_run();
  end
endmodule